// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog counter. It counts ticks from one of two clock-enable sources. One source is a tick from a dedicated free-running oscillator. The other is a tick at the instruction rate, which is the system clock divided by four. The counter has two stages: an 8-bit prescaler, then a 7-bit counter that steps each time the prescaler wraps. A 3-bit period select picks one of eight timeout lengths. When the selected length has elapsed, the block raises a one-cycle timeout pulse. The surrounding logic uses that pulse to reset the device or to wake it from halt.

The source choice and the oscillator enable are configuration levels that are fixed for a build. When the oscillator source is chosen, the timer keeps counting while the device is halted. This lets the watchdog wake a sleeping device. When the instruction-rate source is chosen, halting the device freezes the count. Software keeps the timer from firing by pulsing the clear input at intervals. After a timeout the count wraps and keeps going, so the pulse repeats with the selected period until software clears the timer.

Top module: `wdog_tap_timer`

## Requirements
- R1: After reset `timeout_o` is 0, and both counter stages start from zero. The first pulse after reset therefore needs a full selected period of counted ticks.
- R2: A `period_sel_i` value of n (0 to 7) makes the timeout fire on the 2^(8+n)-th counted tick.
- R3: `timeout_o` is high for exactly one clock cycle. It is the cycle that follows the clock edge that samples the final counted tick.
- R4: After a timeout both stages keep counting from their wrapped values. With no clear in between, the next pulse follows another 2^(8+n) counted ticks.
- R5: While `clear_i` is 1, both stages return to zero at the next edge, and a tick sampled in that cycle is not counted. A timeout that the same cycle would have produced is dropped, so `timeout_o` is 0 in the following cycle.
- R6: With `src_sel_i` = 0 (instruction-rate source), only `instr_tick_i` is counted and `osc_tick_i` has no effect.
- R7: With `src_sel_i` = 1 (oscillator source) and `osc_en_i` = 1, only `osc_tick_i` is counted and `instr_tick_i` has no effect.
- R8: With `src_sel_i` = 1 and `osc_en_i` = 0, nothing is counted and no timeout occurs.
- R9: With `src_sel_i` = 0, an `instr_tick_i` is not counted while `halt_i` is 1. With `src_sel_i` = 1, `halt_i` has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 1 | Static source choice: 0 for instruction-rate tick, 1 for oscillator tick |
| osc_en_i | input | 1 | Static enable for the oscillator source |
| osc_tick_i | input | 1 | Clock enable from the dedicated watchdog oscillator |
| instr_tick_i | input | 1 | Clock enable at the instruction rate |
| period_sel_i | input | 3 | Timeout select n; the period is 2^(8+n) ticks |
| clear_i | input | 1 | Software clear of both counter stages |
| halt_i | input | 1 | Device is in halt mode |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
The period select is tried at its low end, at a middle value and at its maximum with ticks on every cycle. Value 3 is also run with ticks only on every third cycle. Together these separate a wrong tap choice from a counter that runs on clock cycles instead of ticks. A long free run at the shortest period checks the wrap and repeat timing. Clears are placed both mid-period and on the exact final tick, which shows whether the clear takes priority over the tick and drops the pending pulse. Each source is fed with the other source toggling, with halt toggling, and with the oscillator disabled. This tells apart the gating of each source from the gating by halt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned WDOG_PRE_W = 8;
    localparam int unsigned WDOG_CNT_W = 7;
    localparam int unsigned WDOG_SEL_W = 3;

    typedef enum logic {
        WDOG_SRC_INSTR = 1'b0,
        WDOG_SRC_OSC   = 1'b1
    } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import wdog_pkg::*;
(
    input  logic src_sel_i,
    input  logic osc_en_i,
    input  logic osc_tick_i,
    input  logic instr_tick_i,
    input  logic halt_i,
    output logic tick_o
);
    wdog_src_e src;

    always_comb begin
        src = wdog_src_e'(src_sel_i);
        unique case (src)
            WDOG_SRC_OSC:   tick_o = osc_en_i & osc_tick_i;
            WDOG_SRC_INSTR: tick_o = instr_tick_i & ~halt_i;
            default:        tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdog_tap_sel.sv
module wdog_tap_sel #(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    localparam int unsigned TAPS = CNT_W + 1;

    // reach[k] is high when this step carries into bit k (k = CNT_W: carry out)
    logic [TAPS-1:0] reach;

    assign reach[0] = step_i;

    genvar k;
    generate
        for (k = 0; k < CNT_W; k++) begin : g_chain
            assign reach[k+1] = reach[k] & cnt_i[k];
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (int'(sel_i) == i) hit_o = reach[i];
        end
    end
endmodule

// File: rtl/wdog_tap_timer.sv
module wdog_tap_timer
    import wdog_pkg::*;
#(
    parameter int unsigned PRE_W = WDOG_PRE_W,
    parameter int unsigned CNT_W = WDOG_CNT_W,
    parameter int unsigned SEL_W = WDOG_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel_i,
    input  logic             osc_en_i,
    input  logic             osc_tick_i,
    input  logic             instr_tick_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic             clear_i,
    input  logic             halt_i,
    output logic             timeout_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             timeout;
    } wdog_state_t;

    wdog_state_t st_d, st_q;

    logic tick;
    logic pre_wrap;
    logic tap_hit;

    wdog_tick_sel u_tick_sel (
        .src_sel_i   (src_sel_i),
        .osc_en_i    (osc_en_i),
        .osc_tick_i  (osc_tick_i),
        .instr_tick_i(instr_tick_i),
        .halt_i      (halt_i),
        .tick_o      (tick)
    );

    assign pre_wrap = tick & (&st_q.pre);

    wdog_tap_sel #(
        .CNT_W(CNT_W),
        .SEL_W(SEL_W)
    ) u_tap_sel (
        .cnt_i (st_q.cnt),
        .step_i(pre_wrap),
        .sel_i (period_sel_i),
        .hit_o (tap_hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pre     = st_q.pre + PRE_W'(tick);
        st_d.cnt     = st_q.cnt + CNT_W'(pre_wrap);
        st_d.timeout = tap_hit;
        if (clear_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout_o = st_q.timeout;
endmodule

// File: rtl/wdog_tap_timer_chk.sv
module wdog_tap_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic src_sel_i,
    input logic osc_en_i,
    input logic osc_tick_i,
    input logic instr_tick_i,
    input logic clear_i,
    input logic halt_i,
    input logic timeout_o
);
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !timeout_o);

    assert_instr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && !instr_tick_i) |=> !timeout_o);

    assert_osc_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i && !osc_tick_i) |=> !timeout_o);

    assert_osc_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i && !osc_en_i) |=> !timeout_o);

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && halt_i) |=> !timeout_o);
endmodule

bind wdog_tap_timer wdog_tap_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel_i   (src_sel_i),
    .osc_en_i    (osc_en_i),
    .osc_tick_i  (osc_tick_i),
    .instr_tick_i(instr_tick_i),
    .clear_i     (clear_i),
    .halt_i      (halt_i),
    .timeout_o   (timeout_o)
);

// File: tb/tb_wdog_tap_timer.sv
module tb_wdog_tap_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       src_sel, osc_en, osc_tick, instr_tick, clear, halt;
    logic [2:0] period_sel;
    logic       timeout;

    int unsigned checks = 0;
    int unsigned errors = 0;
    longint unsigned cyc = 0;
    longint unsigned eff = 0;
    longint unsigned exp_q[$];
    string cur_req = "R1";
    bit    done = 1'b0;
    bit    run_on = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wdog_tap_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel_i   (src_sel),
        .osc_en_i    (osc_en),
        .osc_tick_i  (osc_tick),
        .instr_tick_i(instr_tick),
        .period_sel_i(period_sel),
        .clear_i     (clear),
        .halt_i      (halt),
        .timeout_o   (timeout)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every observed pulse must match the head of the expectation queue (R3)
    always @(negedge clk) begin
        if (run_on && timeout) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3/%s: pulse at cycle %0d, expected none", cur_req, cyc);
            end else begin
                longint unsigned e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL R3/%s: pulse at cycle %0d, expected %0d", cur_req, cyc, e);
                end
            end
        end
    end

    function automatic longint unsigned period_of(input logic [2:0] s);
        return longint'(1) << (8 + s);
    endfunction

    // Driver: apply one cycle of stimulus and push the expected pulse cycle
    task automatic step(input logic it, input logic ot, input logic hl, input logic cl);
        logic counts;
        @(negedge clk);
        instr_tick = it;
        osc_tick   = ot;
        halt       = hl;
        clear      = cl;
        counts = src_sel ? (ot & osc_en) : (it & ~hl);
        if (cl) begin
            eff = 0;
        end else if (counts) begin
            eff++;
            if (eff % period_of(period_sel) == 0) exp_q.push_back(cyc + 1);
        end
    endtask

    task automatic configure(input logic s, input logic en, input logic [2:0] p);
        @(negedge clk);
        src_sel = s;
        osc_en = en;
        period_sel = p;
        clear = 1'b1;
        instr_tick = 1'b0;
        osc_tick = 1'b0;
        halt = 1'b0;
        eff = 0;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic settle(input string req);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d pulse(s) missing, next expected at %0d, actual none",
                     req, exp_q.size(), exp_q[0]);
            exp_q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run not finished, actual hung, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        src_sel = 1'b0; osc_en = 1'b1; osc_tick = 1'b0; instr_tick = 1'b0;
        clear = 1'b0; halt = 1'b0; period_sel = 3'd0;
        repeat (3) @(negedge clk);
        checks++;
        if (timeout !== 1'b0) begin
            errors++;
            $display("FAIL R1: timeout during reset actual %b expected 0", timeout);
        end
        rst_n = 1'b1;
        run_on = 1'b1;

        // R1 / R2: first pulse after reset, select 0, ticks every cycle
        cur_req = "R1";
        for (int i = 0; i < 256; i++) step(1, 0, 0, 0);
        settle("R1");

        // R4: wrap and repeat at select 0
        cur_req = "R4";
        for (int i = 0; i < 1100; i++) step(1, 0, 0, 0);
        settle("R4");

        // R2: middle select
        configure(1'b0, 1'b1, 3'd2);
        cur_req = "R2";
        for (int i = 0; i < 2100; i++) step(1, 0, 0, 0);
        settle("R2");

        // R2: sparse ticks, select 3
        configure(1'b0, 1'b1, 3'd3);
        for (int i = 0; i < 6200; i++) step((i % 3) == 0, 0, 0, 0);
        settle("R2");

        // R2: maximum select (carry out of second stage)
        configure(1'b0, 1'b1, 3'd7);
        for (int i = 0; i < 32800; i++) step(1, 0, 0, 0);
        settle("R2");

        // R5: clear mid-period and clear on the final tick
        configure(1'b0, 1'b1, 3'd0);
        cur_req = "R5";
        for (int i = 0; i < 200; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        for (int i = 0; i < 255; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0);
        settle("R5");

        // R6: oscillator ticks ignored on instruction source
        configure(1'b0, 1'b1, 3'd0);
        cur_req = "R6";
        for (int i = 0; i < 600; i++) step(0, 1, 0, 0);
        for (int i = 0; i < 300; i++) step(1, 1, 0, 0);
        settle("R6");

        // R7: instruction ticks ignored on oscillator source
        configure(1'b1, 1'b1, 3'd0);
        cur_req = "R7";
        for (int i = 0; i < 600; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 700; i++) step(1, (i % 2) == 0, 0, 0);
        settle("R7");

        // R8: oscillator disabled
        configure(1'b1, 1'b0, 3'd0);
        cur_req = "R8";
        for (int i = 0; i < 1500; i++) step(1, 1, 0, 0);
        settle("R8");

        // R9: halt freezes the instruction source
        configure(1'b0, 1'b1, 3'd0);
        cur_req = "R9";
        for (int i = 0; i < 900; i++) step(1, 0, (i % 3) != 0, 0);
        settle("R9");

        // R9: halt does not stop the oscillator source
        configure(1'b1, 1'b1, 3'd1);
        for (int i = 0; i < 1100; i++) step(0, 1, 1, 0);
        settle("R9");

        finish_run();
    end
endmodule